// File: doc/BRIEF.md
# I/Q FM Discriminator

This block takes complex baseband samples from a down converter and returns the instantaneous frequency of the FM signal they carry. Each accepted I/Q pair is compared with the pair accepted before it. The block forms the first differences of I and of Q. It then computes the cross-product of each component with the change in the other component, which is proportional to the rate of change of the phase angle.

Two modes are available, and the mode is chosen separately for every sample. In raw mode the block emits the cross-product directly. An FM signal has a constant envelope, so the scale of this value is fixed, and raw mode accepts a new sample on every clock. In normalized mode the cross-product is divided by the instantaneous power I² + Q² using a bit-serial divider. This removes the dependence on amplitude. While the division is in progress the block drops its ready output, and the upstream source holds its sample until ready returns. All intermediate products keep their full width, and the final value is clamped to the output width.

Top module: `fm_disc`

## Requirements
- R1: While reset is active and right after it, ready_o is 1, out_valid_o is 0 and freq_o is 0.
- R2: Differences are taken against the previously accepted sample: dI = I[n] − I[n−1] and dQ = Q[n] − Q[n−1]. The previous sample is (0, 0) after reset.
- R3: In raw mode (norm_en_i = 0 with the sample) the output is I·dQ − Q·dI, computed without loss of width, so a phase that advances counter-clockwise gives a positive value.
- R4: Any result outside the signed OUT_W range is clamped to the nearest limit, −2^(OUT_W−1) or 2^(OUT_W−1)−1, and is never wrapped.
- R5: In normalized mode (norm_en_i = 1 with the sample) the output is (I·dQ − Q·dI)·2^FRAC_W / (I² + Q²), truncated toward zero and then clamped as in R4.
- R6: In normalized mode, when I² + Q² is zero the output is 0.
- R7: A raw-mode sample accepted at a clock edge produces out_valid_o after the third edge, counting the accepting edge as the first. Raw samples can be accepted on every cycle.
- R8: A normalized sample appears after NW+4 edges, counting the accepting edge, where NW = 2·IN_W + 2 + FRAC_W. ready_o is 0 from the cycle after the accept until the edge that presents the result.
- R9: A sample presented while ready_o is 0 is not taken. It neither produces an output nor replaces the stored previous sample.
- R10: The mode travels with each sample, so raw and normalized samples can be interleaved freely and results come out in accept order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An input sample is present |
| norm_en_i | input | 1 | 1 selects normalized mode for this sample |
| i_i | input | IN_W | In-phase sample, two's complement |
| q_i | input | IN_W | Quadrature sample, two's complement |
| ready_o | output | 1 | The block accepts a sample on this cycle |
| out_valid_o | output | 1 | freq_o holds a new result (one-cycle pulse) |
| freq_o | output | OUT_W | Frequency estimate, two's complement |

## Verification
The bench runs a small configuration. It walks every I/Q pair as one continuous stream in raw mode and again in normalized mode, so the differences cover every previous/current combination in the sweep. Reversing the sign convention or the operand order of the cross-product would invert or corrupt the raw results. Wrapping instead of clamping would show up on the extreme pairs as values of the wrong sign. Forgetting the zero-magnitude case would return whatever the divider produced for the origin point. Rounding toward minus infinity would make negative normalized quotients one step too low. While each division runs, the bench drives junk samples with valid high. A block that accepted them would emit extra outputs and would take its next differences from the wrong base. Every result's latency is measured against the fixed count, and a final mixed-mode run checks that the mode is kept per sample.

// File: rtl/fm_disc_pkg.sv
package fm_disc_pkg;
  typedef enum logic {MODE_RAW = 1'b0, MODE_NORM = 1'b1} fm_mode_e;

  function automatic int cross_width(input int in_w);
    return 2 * in_w + 2;
  endfunction

  function automatic int quot_width(input int in_w, input int frac_w);
    return 2 * in_w + 2 + frac_w;
  endfunction
endpackage

// File: rtl/fm_diff.sv
module fm_diff #(
  parameter int IN_W = 8,
  localparam int D_W = IN_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] i_i,
  input  logic signed [IN_W-1:0] q_i,
  output logic signed [IN_W-1:0] i_o,
  output logic signed [IN_W-1:0] q_o,
  output logic signed [D_W-1:0]  di_o,
  output logic signed [D_W-1:0]  dq_o
);
  logic signed [IN_W-1:0] prev_i_q, prev_q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_i_q <= '0;
      prev_q_q <= '0;
      i_o      <= '0;
      q_o      <= '0;
      di_o     <= '0;
      dq_o     <= '0;
    end else if (en_i) begin
      prev_i_q <= i_i;
      prev_q_q <= q_i;
      i_o      <= i_i;
      q_o      <= q_i;
      di_o     <= {i_i[IN_W-1], i_i} - {prev_i_q[IN_W-1], prev_i_q};
      dq_o     <= {q_i[IN_W-1], q_i} - {prev_q_q[IN_W-1], prev_q_q};
    end
  end
endmodule

// File: rtl/fm_cross.sv
module fm_cross #(
  parameter int IN_W = 8,
  localparam int D_W   = IN_W + 1,
  localparam int P_W   = IN_W + D_W,
  localparam int CR_W  = P_W + 1,
  localparam int MAG_W = 2 * IN_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] i_i,
  input  logic signed [IN_W-1:0] q_i,
  input  logic signed [D_W-1:0]  di_i,
  input  logic signed [D_W-1:0]  dq_i,
  output logic signed [CR_W-1:0] cross_o,
  output logic        [MAG_W-1:0] mag_o
);
  logic signed [P_W-1:0]   i_dq, q_di;
  logic signed [MAG_W-1:0] i_sq, q_sq;
  logic signed [CR_W-1:0]  cross_d;
  logic        [MAG_W-1:0] mag_d;

  always_comb begin
    i_dq    = P_W'(i_i) * P_W'(dq_i);
    q_di    = P_W'(q_i) * P_W'(di_i);
    cross_d = CR_W'(i_dq) - CR_W'(q_di);
    i_sq    = MAG_W'(i_i) * MAG_W'(i_i);
    q_sq    = MAG_W'(q_i) * MAG_W'(q_i);
    // sum of squares never exceeds 2^(MAG_W-1)
    mag_d   = $unsigned(i_sq) + $unsigned(q_sq);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cross_o <= '0;
      mag_o   <= '0;
    end else if (en_i) begin
      cross_o <= cross_d;
      mag_o   <= mag_d;
    end
  end
endmodule

// File: rtl/fm_seq_div.sv
module fm_seq_div #(
  parameter int CR_W   = 18,
  parameter int DEN_W  = 16,
  parameter int FRAC_W = 4,
  localparam int NUM_W = CR_W + FRAC_W,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic signed [CR_W-1:0] num_i,
  input  logic        [DEN_W-1:0] den_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic signed [NUM_W:0]  quo_o
);
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q;
  logic [DEN_W:0]   rem_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q, zero_q, ge;
  logic [CR_W-1:0]  num_abs;

  always_comb begin
    num_abs = num_i[CR_W-1] ? (~num_i + 1'b1) : num_i;
    rem_sh  = {rem_q, quo_q[NUM_W-1]};
    ge      = rem_sh >= {1'b0, den_q};
    rem_d   = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
    quo_d   = {quo_q[NUM_W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_q  <= {num_abs, {FRAC_W{1'b0}}};
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= '0;
        neg_q  <= num_i[CR_W-1];
        zero_q <= (den_i == '0);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NUM_W - 1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (zero_q)     quo_o = '0;
    else if (neg_q) quo_o = -$signed({1'b0, quo_q});
    else            quo_o = $signed({1'b0, quo_q});
  end
endmodule

// File: rtl/fm_sat.sv
module fm_sat #(
  parameter int W_I = 18,
  parameter int W_O = 12
) (
  input  logic signed [W_I-1:0] d_i,
  output logic signed [W_O-1:0] d_o
);
  if (W_I > W_O) begin : g_clip
    localparam logic signed [W_I-1:0] MAX_V = {{(W_I-W_O+1){1'b0}}, {(W_O-1){1'b1}}};
    localparam logic signed [W_I-1:0] MIN_V = {{(W_I-W_O+1){1'b1}}, {(W_O-1){1'b0}}};
    always_comb begin
      if (d_i > MAX_V)      d_o = MAX_V[W_O-1:0];
      else if (d_i < MIN_V) d_o = MIN_V[W_O-1:0];
      else                  d_o = d_i[W_O-1:0];
    end
  end else if (W_I == W_O) begin : g_pass
    assign d_o = d_i;
  end else begin : g_ext
    assign d_o = {{(W_O-W_I){d_i[W_I-1]}}, d_i};
  end
endmodule

// File: rtl/fm_disc.sv
module fm_disc #(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic                    norm_en_i,
  input  logic signed [IN_W-1:0]  i_i,
  input  logic signed [IN_W-1:0]  q_i,
  output logic                    ready_o,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] freq_o
);
  import fm_disc_pkg::*;

  localparam int D_W   = IN_W + 1;
  localparam int CR_W  = cross_width(IN_W);
  localparam int MAG_W = 2 * IN_W;
  localparam int NUM_W = quot_width(IN_W, FRAC_W);

  logic                    accept;
  logic                    s1_v, s2_v;
  fm_mode_e                s1_m, s2_m;
  logic signed [IN_W-1:0]  s1_i, s1_q;
  logic signed [D_W-1:0]   s1_di, s1_dq;
  logic signed [CR_W-1:0]  s2_cross;
  logic        [MAG_W-1:0] s2_mag;
  logic                    div_busy, div_done;
  logic signed [NUM_W:0]   div_quo;
  logic signed [OUT_W-1:0] raw_sat, norm_sat;

  // stall while a normalized sample is anywhere in flight
  assign ready_o = !(div_busy || (s1_v && s1_m == MODE_NORM) || (s2_v && s2_m == MODE_NORM));
  assign accept  = in_valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_m <= MODE_RAW;
      s2_m <= MODE_RAW;
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
      if (accept) s1_m <= fm_mode_e'(norm_en_i);
      if (s1_v)   s2_m <= s1_m;
    end
  end

  fm_diff #(.IN_W(IN_W)) u_diff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (accept),
    .i_i   (i_i),
    .q_i   (q_i),
    .i_o   (s1_i),
    .q_o   (s1_q),
    .di_o  (s1_di),
    .dq_o  (s1_dq)
  );

  fm_cross #(.IN_W(IN_W)) u_cross (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (s1_v),
    .i_i    (s1_i),
    .q_i    (s1_q),
    .di_i   (s1_di),
    .dq_i   (s1_dq),
    .cross_o(s2_cross),
    .mag_o  (s2_mag)
  );

  fm_seq_div #(.CR_W(CR_W), .DEN_W(MAG_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(s2_v && s2_m == MODE_NORM),
    .num_i  (s2_cross),
    .den_i  (s2_mag),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  fm_sat #(.W_I(CR_W), .W_O(OUT_W)) u_sat_raw (
    .d_i(s2_cross),
    .d_o(raw_sat)
  );

  fm_sat #(.W_I(NUM_W + 1), .W_O(OUT_W)) u_sat_norm (
    .d_i(div_quo),
    .d_o(norm_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      freq_o      <= '0;
    end else if (s2_v && s2_m == MODE_RAW) begin
      out_valid_o <= 1'b1;
      freq_o      <= raw_sat;
    end else if (div_done) begin
      out_valid_o <= 1'b1;
      freq_o      <= norm_sat;
    end else begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fm_disc_chk.sv
module fm_disc_chk #(
  parameter int IN_W   = 8,
  parameter int FRAC_W = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic norm_en_i,
  input logic ready_o,
  input logic out_valid_o
);
  localparam int LAT_N = 2 * IN_W + 2 + FRAC_W + 4;
  localparam int LC_W  = $clog2(LAT_N + 1);

  logic            acc;
  logic [2:0]      pend_q;
  logic [LC_W-1:0] ncnt_q;
  logic            nact_q;

  assign acc = in_valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ncnt_q <= '0;
      nact_q <= 1'b0;
    end else begin
      pend_q <= pend_q + {2'b0, acc} - {2'b0, out_valid_o};
      if (acc && norm_en_i) begin
        nact_q <= 1'b1;
        ncnt_q <= LC_W'(LAT_N - 1);
      end else if (nact_q) begin
        if (ncnt_q == '0) nact_q <= 1'b0;
        else              ncnt_q <= ncnt_q - 1'b1;
      end
    end
  end

  // R8
  norm_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ready_o && norm_en_i) |=> !ready_o);

  // R7
  raw_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && ready_o && !norm_en_i, 3) |-> out_valid_o);

  // R8
  norm_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nact_q && ncnt_q == '0) |-> out_valid_o);

  // R9
  no_spurious_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (pend_q != '0));
endmodule

bind fm_disc fm_disc_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fm_disc_tb.sv
module fm_disc_tb_top;
  localparam int IN_W   = 4;
  localparam int OUT_W  = 8;
  localparam int FRAC_W = 4;
  localparam int NW     = 2 * IN_W + 2 + FRAC_W;
  localparam int LAT_R  = 3;
  localparam int LAT_N  = NW + 4;
  localparam int OMAX   = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN   = -(1 << (OUT_W - 1));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic norm_en_i = 1'b0;
  logic signed [IN_W-1:0] i_i = '0;
  logic signed [IN_W-1:0] q_i = '0;
  logic ready_o, out_valid_o;
  logic signed [OUT_W-1:0] freq_o;

  fm_disc #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  int errors = 0, checks = 0, cyc = 0;
  int prev_i = 0, prev_q = 0;
  int exp_v[0:1023];
  int exp_c[0:1023];
  int exp_l[0:1023];
  string exp_t[0:1023];
  int wr = 0, rd = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  // one sample: junk is offered while the block stalls
  task automatic push(input int iv, input int qv, input bit nrm, input string tag);
    int cr, mg, ev;
    string t;
    bit stalled;
    stalled = 1'b0;
    @(negedge clk_i);
    while (!ready_o) begin
      stalled    = 1'b1;
      in_valid_i = 1'b1;
      norm_en_i  = ~nrm;
      i_i        = IN_W'(iv + 3);
      q_i        = IN_W'(qv - 5);
      @(negedge clk_i);
    end
    in_valid_i = 1'b1;
    norm_en_i  = nrm;
    i_i        = IN_W'(iv);
    q_i        = IN_W'(qv);
    cr = iv * (qv - prev_q) - qv * (iv - prev_i);
    mg = iv * iv + qv * qv;
    t  = tag;
    if (nrm) begin
      if (mg == 0) begin ev = 0; t = "R6"; end
      else ev = sat((cr * (1 << FRAC_W)) / mg);
      if (stalled) t = {t, "+R9"};
    end else begin
      ev = sat(cr);
      if (ev != cr) t = "R4";
    end
    exp_v[wr] = ev;
    exp_c[wr] = cyc;
    exp_l[wr] = nrm ? LAT_N : LAT_R;
    exp_t[wr] = t;
    wr++;
    prev_i = iv;
    prev_q = qv;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (rd >= wr) begin
        chk(1'b0, "R9", int'(freq_o), 0);
      end else begin
        chk(int'(freq_o) == exp_v[rd], exp_t[rd], int'(freq_o), exp_v[rd]);
        chk(cyc - exp_c[rd] == exp_l[rd], exp_l[rd] == LAT_R ? "R7" : "R8",
            cyc - exp_c[rd], exp_l[rd]);
        rd++;
      end
    end
  end

  initial begin
    #1;
    chk(ready_o == 1'b1, "R1", int'(ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R1", int'(ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
    chk(freq_o == '0, "R1", int'(freq_o), 0);

    // raw sweep, back to back; first sample differs from (0,0) for R2
    push(-3, 5, 1'b0, "R2");
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        push(a, b, 1'b0, "R3");
    idle(6);

    // normalized sweep, origin included for R6
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        push(b, a, 1'b1, "R5");
    idle(LAT_N + 2);

    // interleaved modes
    for (int k = 0; k < 32; k++)
      push(((k * 5) % 16) - 8, ((k * 11) % 16) - 8, k[0] ^ k[2], "R10");
    idle(LAT_N + 4);

    chk(rd == wr, "R7", rd, wr);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    chk(1'b0, "R7", rd, wr);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule